// File: doc/BRIEF.md
# Time-Target Compare and Event Output Unit

This block watches a free-running 64-bit time value and compares it with a programmable 64-bit target. When the time reaches the target, the block sets a sticky timer interrupt flag. It then moves the target forward in one of two ways. It either loads the target from a 64-bit step register, or it adds the step value to the current target, which gives periodic events.

Two event pins follow each compare event. Each pin has its own mode: a fixed-width pulse, a toggle, a level copy of the interrupt flag, or held inactive. Each pin also has its own polarity and its own enable. When a pin's enable is clear, the pin passes through the value on its general-purpose input.

Software reaches the registers through a 32-bit write port and a combinational read port. A 64-bit register is written as two halves. The low half is held aside and takes effect together with the high half.

Top module: `ptp_target_cmp`

## Requirements
- R1: The time input is registered once. A compare event occurs in every cycle in which the registered time is greater than or equal to the committed target. The flag is set at the next clock edge, so it becomes visible two edges after the time input reaches the target. If the time jumps past the target in one step, exactly one event occurs, provided the advanced target lies beyond the time.
- R2: With control bit 0 at 0, each event replaces the target with the step register (address 2 holds its low half, address 3 its high half).
- R3: With control bit 0 at 1, each event adds the step register to the target, modulo 2^64.
- R4: Address 0 holds the target's low half and address 1 its high half. A write to address 0 or 2 is only staged and leaves the committed value and its readback unchanged. A write to address 1 or 3 commits the high word together with the staged low word. A software write to the target overrides the advance from an event in the same cycle.
- R5: The flag is read at address 5, bit 0. It stays set until software writes 1 to that bit. A written 0 has no effect. An event in the same cycle as a clear leaves the flag set.
- R6: Pin mode 00 (pulse) makes the pin active for PULSE_CYC cycles, starting at the edge that sets the flag. An event during an active pulse restarts the full width.
- R7: Pin mode 01 (toggle) inverts the pin's active state on every event.
- R8: Pin mode 10 (level) makes the pin active exactly while the flag is set.
- R9: Pin mode 11 holds the pin at its inactive level.
- R10: The polarity bit of a pin (control bit 7 for pin 0, bit 8 for pin 1) makes it active low when set. The inactive level is then 1.
- R11: When a pin's enable bit (control bit 5 for pin 0, bit 6 for pin 1) is 0, the pin equals its general-purpose input. The mode field of pin 0 is control bits 2:1, and that of pin 1 is bits 4:3. The control register is at address 4.
- R12: After reset the target is all ones, the step register is zero, control reads 0, the flag is clear, and both pins are in pass-through.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clk_time | input | 64 | Running time value |
| gp_in | input | 2 | General-purpose pin values used when an event pin is not enabled |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | 32 | Register write data |
| rd_addr | input | 3 | Register read address |
| rd_data | output | 32 | Register read data, combinational |
| pin_out | output | 2 | Event pin outputs |

## Verification
On every cycle, the assertions check the following:
- A detected compare sets the flag.
- The flag is sticky unless it is cleared.
- A low-half write leaves the target untouched.
- A pin in pass-through follows its input.
- Mode 11 holds its inactive level.
- An event starts an enabled pulse.

The full pulse width, restart, toggle parity, reload against add arithmetic, and the exact event count after a jump past the target need the bench's scenarios. There, a reference model tracks the registers through constrained random traffic and through directed corner cases.

// File: rtl/ptp_target_cmp.sv
module ptp_target_cmp #(
  parameter int DW        = 32,
  parameter int NPIN      = 2,
  parameter int PULSE_CYC = 5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [2*DW-1:0] clk_time,
  input  logic [NPIN-1:0] gp_in,
  input  logic            wr_en,
  input  logic [2:0]      wr_addr,
  input  logic [DW-1:0]   wr_data,
  input  logic [2:0]      rd_addr,
  output logic [DW-1:0]   rd_data,
  output logic [NPIN-1:0] pin_out
);
  localparam int TW   = 2 * DW;
  localparam int CTW  = 1 + 4 * NPIN;
  localparam int OE0  = 1 + 2 * NPIN;
  localparam int POL0 = 1 + 3 * NPIN;
  localparam int CW   = $clog2(PULSE_CYC + 1);

  logic [TW-1:0]  time_q, tgt_q, rld_q;
  logic [DW-1:0]  tlo_stage, rlo_stage;
  logic [CTW-1:0] ctrl_q;
  logic           flag_q;
  logic           hit, clr, w_tlo, w_thi, w_rlo, w_rhi, w_ctl;

  assign hit   = time_q >= tgt_q;
  assign w_tlo = wr_en && wr_addr == 3'd0;
  assign w_thi = wr_en && wr_addr == 3'd1;
  assign w_rlo = wr_en && wr_addr == 3'd2;
  assign w_rhi = wr_en && wr_addr == 3'd3;
  assign w_ctl = wr_en && wr_addr == 3'd4;
  assign clr   = wr_en && wr_addr == 3'd5 && wr_data[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      time_q    <= '0;
      tgt_q     <= '1;
      rld_q     <= '0;
      tlo_stage <= '0;
      rlo_stage <= '0;
      ctrl_q    <= '0;
      flag_q    <= 1'b0;
    end else begin
      time_q <= clk_time;
      if (w_tlo) tlo_stage <= wr_data;
      if (w_rlo) rlo_stage <= wr_data;
      if (w_ctl) ctrl_q <= wr_data[CTW-1:0];
      if (w_rhi) rld_q <= {wr_data, rlo_stage};
      if (w_thi)    tgt_q <= {wr_data, tlo_stage};
      else if (hit) tgt_q <= ctrl_q[0] ? tgt_q + rld_q : rld_q;
      if (hit)      flag_q <= 1'b1;
      else if (clr) flag_q <= 1'b0;
    end
  end

  for (genvar i = 0; i < NPIN; i++) begin : g_pin
    logic [CW-1:0] cnt;
    logic          tog, act;
    logic [1:0]    mode;

    assign mode = ctrl_q[2*i+1 +: 2];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cnt <= '0;
        tog <= 1'b0;
      end else if (hit) begin
        cnt <= CW'(PULSE_CYC);
        tog <= ~tog;
      end else if (cnt != '0) begin
        cnt <= cnt - 1'b1;
      end
    end

    always_comb begin
      case (mode)
        2'b00:   act = cnt != '0;
        2'b01:   act = tog;
        2'b10:   act = flag_q;
        default: act = 1'b0;
      endcase
    end

    assign pin_out[i] = ctrl_q[OE0+i] ? (act ^ ctrl_q[POL0+i]) : gp_in[i];
  end

  always_comb begin
    case (rd_addr)
      3'd0:    rd_data = tgt_q[DW-1:0];
      3'd1:    rd_data = tgt_q[TW-1:DW];
      3'd2:    rd_data = rld_q[DW-1:0];
      3'd3:    rd_data = rld_q[TW-1:DW];
      3'd4:    rd_data = {{(DW-CTW){1'b0}}, ctrl_q};
      3'd5:    rd_data = {{(DW-1){1'b0}}, flag_q};
      default: rd_data = '0;
    endcase
  end
endmodule

// File: rtl/ptp_target_cmp_chk.sv
module ptp_target_cmp_chk #(
  parameter int NPIN = 2,
  parameter int TW   = 64,
  parameter int CTW  = 9
) (
  input logic            clk,
  input logic            rst_n,
  input logic            hit,
  input logic            flag_q,
  input logic            clr,
  input logic            w_tlo,
  input logic            w_thi,
  input logic [CTW-1:0]  ctrl_q,
  input logic [TW-1:0]   tgt_q,
  input logic [NPIN-1:0] gp_in,
  input logic [NPIN-1:0] pin_out
);
  localparam int OE0  = 1 + 2 * NPIN;
  localparam int POL0 = 1 + 3 * NPIN;

  assert_event_sets_flag_R1: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> flag_q);

  assert_flag_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q && !clr) |=> flag_q);

  assert_low_half_staged_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (w_tlo && !hit && !w_thi) |=> $stable(tgt_q));

  assert_bypass_pin0_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_q[OE0] |-> pin_out[0] == gp_in[0]);

  assert_bypass_pin1_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_q[OE0+1] |-> pin_out[1] == gp_in[1]);

  assert_reserved_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_q[2:1] == 2'b11 && ctrl_q[OE0]) |-> pin_out[0] == ctrl_q[POL0]);

  assert_pulse_starts_R6: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> (ctrl_q[2:1] != 2'b00 || !ctrl_q[OE0] || pin_out[0] != ctrl_q[POL0]));
endmodule

bind ptp_target_cmp ptp_target_cmp_chk #(.NPIN(NPIN), .TW(TW), .CTW(CTW)) chk_i (
  .clk(clk), .rst_n(rst_n), .hit(hit), .flag_q(flag_q), .clr(clr),
  .w_tlo(w_tlo), .w_thi(w_thi), .ctrl_q(ctrl_q), .tgt_q(tgt_q),
  .gp_in(gp_in), .pin_out(pin_out)
);

// File: tb/ptp_target_cmp_tb.sv
module ptp_target_cmp_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int PULSE      = 5;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [63:0] t;
  logic [1:0]  gp_in;
  logic        wr_en;
  logic [2:0]  wr_addr, rd_addr;
  logic [31:0] wr_data, rd_data;
  logic [1:0]  pin_out;

  int tests = 0, fails = 0;
  bit done = 0;

  ptp_target_cmp #(.PULSE_CYC(PULSE)) dut_i (
    .clk(clk), .rst_n(rst_n), .clk_time(t), .gp_in(gp_in), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
    .pin_out(pin_out));

  always #(CLK_PERIOD/2) clk = ~clk;

  logic [63:0] m_tq, m_tgt, m_rld;
  logic [31:0] m_tlo, m_rlo;
  logic [8:0]  m_ctrl;
  logic        m_flag, mh;
  int          m_cnt [2];
  logic        m_tog [2];

  always @(posedge clk) begin
    if (!rst_n) begin
      m_tq <= 0; m_tgt <= '1; m_rld <= 0; m_tlo <= 0; m_rlo <= 0;
      m_ctrl <= 0; m_flag <= 0;
      for (int i = 0; i < 2; i++) begin m_cnt[i] <= 0; m_tog[i] <= 0; end
    end else begin
      mh = m_tq >= m_tgt;
      m_tq <= t;
      if (wr_en && wr_addr == 0) m_tlo <= wr_data;
      if (wr_en && wr_addr == 2) m_rlo <= wr_data;
      if (wr_en && wr_addr == 3) m_rld <= {wr_data, m_rlo};
      if (wr_en && wr_addr == 4) m_ctrl <= wr_data[8:0];
      if (wr_en && wr_addr == 1) m_tgt <= {wr_data, m_tlo};
      else if (mh) m_tgt <= m_ctrl[0] ? m_tgt + m_rld : m_rld;
      if (mh) m_flag <= 1;
      else if (wr_en && wr_addr == 5 && wr_data[0]) m_flag <= 0;
      for (int i = 0; i < 2; i++) begin
        if (mh) begin m_cnt[i] <= PULSE; m_tog[i] <= ~m_tog[i]; end
        else if (m_cnt[i] != 0) m_cnt[i] <= m_cnt[i] - 1;
      end
    end
  end

  function automatic logic exp_pin(int i);
    logic a;
    case (m_ctrl[2*i+1 +: 2])
      2'b00: a = m_cnt[i] != 0;
      2'b01: a = m_tog[i];
      2'b10: a = m_flag;
      default: a = 0;
    endcase
    return m_ctrl[5+i] ? (a ^ m_ctrl[7+i]) : gp_in[i];
  endfunction

  function automatic string req_of(int i);
    if (!m_ctrl[5+i]) return "R11";
    case (m_ctrl[2*i+1 +: 2])
      2'b00: return "R6";
      2'b01: return "R7";
      2'b10: return "R8";
      default: return "R9";
    endcase
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic rd_chk(input logic [2:0] a, input logic [31:0] exp, input string req);
    rd_addr = a; #1;
    check(req, rd_data, exp);
  endtask

  task automatic tick; @(negedge clk); endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    wr_en = 1; wr_addr = a; wr_data = d;
    tick;
    wr_en = 0;
  endtask

  task automatic model_chk;
    for (int i = 0; i < 2; i++) check(req_of(i), pin_out[i], exp_pin(i));
    rd_chk(5, {31'b0, m_flag}, "R5");
    rd_chk(0, m_tgt[31:0], m_ctrl[0] ? "R3" : "R2");
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    rst_n = 0; t = 0; gp_in = 2'b10; wr_en = 0; wr_addr = 0; wr_data = 0; rd_addr = 0;
    repeat (3) tick;
    rd_chk(1, 32'hFFFF_FFFF, "R12");
    rd_chk(3, 0, "R12");
    rd_chk(4, 0, "R12");
    rd_chk(5, 0, "R12");
    check("R12", pin_out, gp_in);
    rst_n = 1;
    tick;

    wr(0, 100);
    rd_chk(0, 32'hFFFF_FFFF, "R4");
    wr(1, 0);
    rd_chk(0, 100, "R4");
    wr(2, 50); wr(3, 0);
    wr(4, 105);
    t = 99; tick; tick;
    check("R1", pin_out[0], 0);
    t = 100; tick;
    rd_chk(5, 0, "R1");
    tick;
    rd_chk(5, 1, "R1");
    rd_chk(0, 150, "R3");
    check("R6", pin_out[0], 1);
    check("R7", pin_out[1], 1);
    repeat (4) begin tick; check("R6", pin_out[0], 1); end
    tick; check("R6", pin_out[0], 0);

    wr(2, 5000); wr(3, 0); wr(4, 104);
    t = 160; tick; tick;
    rd_chk(0, 5000, "R2");
    check("R7", pin_out[1], 0);
    repeat (3) tick;
    check("R1", pin_out[1], 0);

    wr(5, 0); rd_chk(5, 1, "R5");
    wr(5, 1); rd_chk(5, 0, "R5");
    wr(2, 9000); wr(3, 0);
    t = 5000; tick;
    wr(5, 1);
    rd_chk(5, 1, "R5");
    rd_chk(0, 9000, "R2");

    wr(4, 108); check("R8", pin_out[0], 1);
    wr(5, 1);   check("R8", pin_out[0], 0);
    wr(4, 110); check("R9", pin_out[0], 0);
    wr(4, 238); check("R10", pin_out[0], 1);
    wr(4, 232); check("R10", pin_out[0], 1);

    t = 9000; tick; tick;
    check("R10", pin_out[0], 0);
    repeat (8) begin tick; check("R6", pin_out[0], 0); end
    wr(0, 20000); wr(1, 0);
    check("R6", pin_out[0], 0);
    repeat (4) begin tick; check("R6", pin_out[0], 0); end
    tick; check("R6", pin_out[0], 1);

    wr(4, 0);
    gp_in = 2'b01; #1; check("R11", pin_out, 2'b01);
    gp_in = 2'b10; #1; check("R11", pin_out, 2'b10);

    for (int n = 0; n < 4000; n++) begin
      tick;
      model_chk;
      t = t + ($urandom % 4);
      gp_in = 2'($urandom);
      wr_en = ($urandom % 4) == 0;
      wr_addr = 3'($urandom % 6);
      case (wr_addr)
        3'd0: wr_data = t[31:0] + ($urandom % 40);
        3'd1: wr_data = t[63:32];
        3'd2: wr_data = 1 + ($urandom % 8);
        3'd3: wr_data = 0;
        3'd4: wr_data = {23'b0, 9'($urandom)} | 32'(($urandom % 4) != 0);
        default: wr_data = 32'($urandom % 2);
      endcase
    end
    wr_en = 0;
    tick; model_chk;

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule